// File: doc/BRIEF.md
# Flash Embedded-Algorithm Status Generator

This block forms the status byte that a flash memory returns to the host while an embedded program or erase algorithm runs, and it drives the active-low busy flag. A command controller, not part of this block, reports the algorithm mode, a time-limit flag, bit 7 of the data being programmed, and which sectors are selected for erase or have failed. The host read strobes (chip enable and output enable) and the sector index of the read address decide what each read access returns. That value is either the polling status byte or the array data passed through from the memory core.

A read access starts when both strobes go low. The block samples its inputs at that start and presents the result on `dout` one clock later. It holds that value until the next access. There are two toggle flip-flops. One is the general toggle bit (bit 6), which flips on every access while an algorithm is active. The other is the sector toggle bit (bit 2), which flips only on accesses that hit a sector being erased or suspended. As a result, the status a host sees depends on the address it polls. Two short polling windows are also built in. They stand in for a program or erase aimed at a protected sector, which shows busy status briefly and then returns to array reads.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst` is high and on the cycle after it, `dout` is 0x00 and `busy_n` is 1. Both toggle bits are cleared, so the first status read shows 0 in bits 6 and 2.
- R2: An access starts on a clock where `ce_n` and `oe_n` are both low after not both being low. The byte for that access appears on `dout` after the next rising edge and is held until the next access starts. With no status shown, `dout` equals `array_data` as sampled at the access start.
- R3: Bit 6 of the status byte inverts on every access in modes 1, 2, 3, 4 and 6 and during a protected window. It is held in mode 5, and no status is shown in mode 0.
- R4: Status byte layout: bit 7 is the data-poll bit, bit 6 the general toggle, bit 5 the time-limit flag, bit 3 the erase-started flag, and bit 2 the sector toggle. Bits 4, 1 and 0 read 0. In modes 1 and 6, bit 7 is the inverse of `prog_d7`. In modes 2, 3 and 4, bit 7 is 0.
- R5: In modes 1, 3, 4 and 6, bit 5 equals `timed_out`. A timed-out algorithm keeps bit 6 toggling and drives `busy_n` high.
- R6: Bit 3 is 0 in mode 2 (sector-erase window still open) and 1 in modes 3 and 4.
- R7: In modes 2, 3 and 6, bit 2 inverts only on accesses whose sector index has its bit set in `erase_sel`; other accesses see it held. In mode 1, bit 2 is held.
- R8: In mode 4 without a timeout, bit 2 inverts on every access. With `timed_out` set in modes 3 or 4, bit 2 inverts only at sectors set in `fail_sel`.
- R9: In mode 5, an access to a sector set in `erase_sel` returns a status byte with bit 7 = 1, bit 6 held, bits 5 and 3 = 0, and bit 2 inverting. An access to any other sector returns `array_data`.
- R10: `busy_n` follows the inputs with one clock of delay. It is low in modes 1, 2, 3, 4 and 6 when `timed_out` is 0, and during a protected window. It is high in modes 0, 5 and 7.
- R11: A `prot_prog_go` pulse in modes 0 or 7 opens a window of PROT_PROG_CYC clocks, and a `prot_erase_go` pulse opens one of PROT_ERASE_CYC clocks. During the window `busy_n` is low and reads return status: for program, bit 7 = inverse of `prog_d7`; for erase, bit 7 = 0 and bit 3 = 1. Afterwards, reads return array data.
- R12: `alg_mode` codes are 0 idle, 1 program, 2 sector-erase window, 3 sector erase, 4 chip erase, 5 erase-suspended read, 6 program while erase is suspended. Code 7 behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alg_mode | input | 3 | Algorithm mode code (R12) |
| timed_out | input | 1 | Algorithm exceeded its time limit |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| erase_sel | input | NUM_SEC | Sectors selected for erase |
| fail_sel | input | NUM_SEC | Sectors whose erase failed |
| prot_prog_go | input | 1 | Program aimed at a protected sector |
| prot_erase_go | input | 1 | Erase aimed only at protected sectors |
| rd_sector | input | SEC_IDX_W | Sector index of the read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| array_data | input | 8 | Data from the memory core |
| dout | output | 8 | Read data or status byte |
| busy_n | output | 1 | Low while an algorithm is busy |

## Verification
Several rules are checked on every clock: `dout` holds between accesses, the reset values, the busy level in program, suspend and timeout states, the data-poll and erase-started bits, the general toggle flipping and the sector toggle holding during a program, and the upper bound on a protected window. Only the bench scenarios can show the address-dependent behaviour. This covers which sectors make bit 2 move in each erase mode and after a failure, the split between status and array data in suspend, and the exact window lengths counted at the port.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ALG_IDLE      = 3'd0,
        ALG_PROG      = 3'd1,
        ALG_EWIN      = 3'd2,
        ALG_SERASE    = 3'd3,
        ALG_CERASE    = 3'd4,
        ALG_SUSP      = 3'd5,
        ALG_SUSP_PROG = 3'd6,
        ALG_RSVD      = 3'd7
    } alg_mode_e;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_PROG  = 2'd1,
        WIN_ERASE = 2'd2
    } win_kind_e;

    // Per-access decision: what to show and which toggles advance
    typedef struct packed {
        logic show_status;
        logic dq7;
        logic dq6_step;
        logic dq5;
        logic dq3;
        logic dq2_step;
        logic busy;
    } stat_plan_t;

    localparam stat_plan_t PLAN_ARRAY = '{default: 1'b0};

    function automatic logic [DATA_W-1:0] pack_status(
        input stat_plan_t p, input logic t6, input logic t2);
        logic [DATA_W-1:0] b;
        b    = '0;
        b[7] = p.dq7;
        b[6] = t6;
        b[5] = p.dq5;
        b[3] = p.dq3;
        b[2] = t2;
        return b;
    endfunction

endpackage

// File: rtl/fsg_toggle_bit.sv
module fsg_toggle_bit (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (step) q <= ~q;
    end
endmodule

// File: rtl/fsg_sector_match.sv
module fsg_sector_match #(
    parameter int SEC_IDX_W = 4,
    localparam int NUM_SEC  = 1 << SEC_IDX_W
) (
    input  logic [SEC_IDX_W-1:0] sec_idx,
    input  logic [NUM_SEC-1:0]   erase_sel,
    input  logic [NUM_SEC-1:0]   fail_sel,
    output logic                 erase_hit,
    output logic                 fail_hit
);
    logic [NUM_SEC-1:0] onehot;

    for (genvar g = 0; g < NUM_SEC; g++) begin : g_dec
        assign onehot[g] = (sec_idx == SEC_IDX_W'(g));
    end

    assign erase_hit = |(onehot & erase_sel);
    assign fail_hit  = |(onehot & fail_sel);
endmodule

// File: rtl/fsg_prot_timer.sv
module fsg_prot_timer #(
    parameter int PROT_PROG_CYC  = 8,
    parameter int PROT_ERASE_CYC = 40,
    localparam int MAXC  = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC,
    localparam int CNT_W = $clog2(MAXC + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                allow,
    input  logic                go_prog,
    input  logic                go_erase,
    output logic                win_active,
    output fsg_pkg::win_kind_e  win_kind
);
    import fsg_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic             is_erase;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_active <= 1'b0;
            is_erase   <= 1'b0;
            cnt        <= '0;
        end else if (allow && go_erase) begin
            win_active <= 1'b1;
            is_erase   <= 1'b1;
            cnt        <= CNT_W'(PROT_ERASE_CYC - 1);
        end else if (allow && go_prog) begin
            win_active <= 1'b1;
            is_erase   <= 1'b0;
            cnt        <= CNT_W'(PROT_PROG_CYC - 1);
        end else if (win_active) begin
            if (cnt == '0) win_active <= 1'b0;
            else           cnt        <= cnt - 1'b1;
        end
    end

    always_comb begin
        if (!win_active)  win_kind = WIN_NONE;
        else if (is_erase) win_kind = WIN_ERASE;
        else               win_kind = WIN_PROG;
    end
endmodule

// File: rtl/fsg_status_plan.sv
module fsg_status_plan (
    input  fsg_pkg::alg_mode_e  mode,
    input  fsg_pkg::win_kind_e  win_kind,
    input  logic                timed_out,
    input  logic                prog_d7,
    input  logic                erase_hit,
    input  logic                fail_hit,
    output fsg_pkg::stat_plan_t plan
);
    import fsg_pkg::*;

    logic erase_t2;

    // Sector toggle in erase modes: failed sectors only once timed out
    always_comb erase_t2 = timed_out ? fail_hit : erase_hit;

    always_comb begin
        plan = PLAN_ARRAY;
        unique case (mode)
            ALG_PROG: plan = '{show_status: 1'b1, dq7: ~prog_d7, dq6_step: 1'b1,
                               dq5: timed_out, dq3: 1'b0, dq2_step: 1'b0,
                               busy: ~timed_out};
            ALG_EWIN: plan = '{show_status: 1'b1, dq7: 1'b0, dq6_step: 1'b1,
                               dq5: 1'b0, dq3: 1'b0, dq2_step: erase_hit,
                               busy: ~timed_out};
            ALG_SERASE: plan = '{show_status: 1'b1, dq7: 1'b0, dq6_step: 1'b1,
                                 dq5: timed_out, dq3: 1'b1, dq2_step: erase_t2,
                                 busy: ~timed_out};
            ALG_CERASE: plan = '{show_status: 1'b1, dq7: 1'b0, dq6_step: 1'b1,
                                 dq5: timed_out, dq3: 1'b1,
                                 dq2_step: timed_out ? fail_hit : 1'b1,
                                 busy: ~timed_out};
            ALG_SUSP: begin
                if (erase_hit)
                    plan = '{show_status: 1'b1, dq7: 1'b1, dq6_step: 1'b0,
                             dq5: 1'b0, dq3: 1'b0, dq2_step: 1'b1, busy: 1'b0};
                else
                    plan = PLAN_ARRAY;
            end
            ALG_SUSP_PROG: plan = '{show_status: 1'b1, dq7: ~prog_d7, dq6_step: 1'b1,
                                    dq5: timed_out, dq3: 1'b0, dq2_step: erase_hit,
                                    busy: ~timed_out};
            default: begin
                unique case (win_kind)
                    WIN_PROG:  plan = '{show_status: 1'b1, dq7: ~prog_d7, dq6_step: 1'b1,
                                        dq5: 1'b0, dq3: 1'b0, dq2_step: 1'b0, busy: 1'b1};
                    WIN_ERASE: plan = '{show_status: 1'b1, dq7: 1'b0, dq6_step: 1'b1,
                                        dq5: 1'b0, dq3: 1'b1, dq2_step: 1'b0, busy: 1'b1};
                    default:   plan = PLAN_ARRAY;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
    parameter int SEC_IDX_W      = 4,
    parameter int PROT_PROG_CYC  = 8,
    parameter int PROT_ERASE_CYC = 40,
    localparam int NUM_SEC       = 1 << SEC_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           alg_mode,
    input  logic                 timed_out,
    input  logic                 prog_d7,
    input  logic [NUM_SEC-1:0]   erase_sel,
    input  logic [NUM_SEC-1:0]   fail_sel,
    input  logic                 prot_prog_go,
    input  logic                 prot_erase_go,
    input  logic [SEC_IDX_W-1:0] rd_sector,
    input  logic                 ce_n,
    input  logic                 oe_n,
    input  logic [7:0]           array_data,
    output logic [7:0]           dout,
    output logic                 busy_n
);
    import fsg_pkg::*;

    alg_mode_e  mode;
    win_kind_e  win_kind;
    stat_plan_t plan;
    logic       win_active;
    logic       erase_hit, fail_hit;
    logic       rd_act, rd_act_q, rd_start;
    logic       allow_win;
    logic [1:0] tog_step, tog_q;
    logic       tog6, tog2;

    assign mode      = alg_mode_e'(alg_mode);
    assign allow_win = (mode == ALG_IDLE) || (mode == ALG_RSVD);

    // Access start: combined strobe going active
    assign rd_act   = ~ce_n & ~oe_n;
    assign rd_start = rd_act & ~rd_act_q;

    always_ff @(posedge clk) begin
        if (rst) rd_act_q <= 1'b0;
        else     rd_act_q <= rd_act;
    end

    fsg_sector_match #(.SEC_IDX_W(SEC_IDX_W)) u_match (
        .sec_idx   (rd_sector),
        .erase_sel (erase_sel),
        .fail_sel  (fail_sel),
        .erase_hit (erase_hit),
        .fail_hit  (fail_hit)
    );

    fsg_prot_timer #(
        .PROT_PROG_CYC  (PROT_PROG_CYC),
        .PROT_ERASE_CYC (PROT_ERASE_CYC)
    ) u_prot (
        .clk        (clk),
        .rst        (rst),
        .allow      (allow_win),
        .go_prog    (prot_prog_go),
        .go_erase   (prot_erase_go),
        .win_active (win_active),
        .win_kind   (win_kind)
    );

    fsg_status_plan u_plan (
        .mode      (mode),
        .win_kind  (win_kind),
        .timed_out (timed_out),
        .prog_d7   (prog_d7),
        .erase_hit (erase_hit),
        .fail_hit  (fail_hit),
        .plan      (plan)
    );

    // index 0: general toggle (bit 6), index 1: sector toggle (bit 2)
    assign tog_step[0] = rd_start & plan.dq6_step;
    assign tog_step[1] = rd_start & plan.dq2_step;

    for (genvar g = 0; g < 2; g++) begin : g_tog
        fsg_toggle_bit u_tog (
            .clk  (clk),
            .rst  (rst),
            .step (tog_step[g]),
            .q    (tog_q[g])
        );
    end

    assign tog6 = tog_q[0];
    assign tog2 = tog_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= '0;
            busy_n <= 1'b1;
        end else begin
            busy_n <= ~plan.busy;
            if (rd_start)
                dout <= plan.show_status ? pack_status(plan, tog6, tog2) : array_data;
        end
    end
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int PROT_ERASE_CYC = 40
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] alg_mode,
    input logic       timed_out,
    input logic       prog_d7,
    input logic       rd_start,
    input logic [7:0] dout,
    input logic       busy_n,
    input logic       tog6,
    input logic       tog2,
    input logic       win_active
);
    int unsigned win_run;

    always_ff @(posedge clk) begin
        if (rst)             win_run <= 0;
        else if (win_active) win_run <= win_run + 1;
        else                 win_run <= 0;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dout == 8'h00 && busy_n && !tog6 && !tog2)) else $error("reset"); // R1

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_start) |-> $stable(dout)) else $error("hold"); // R2

    AST_DQ6_FLIP_PROG: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_start) && $past(alg_mode) == 3'd1) |-> (tog6 != $past(tog6))) else $error("dq6"); // R3

    AST_DQ7_PROG: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_start) && $past(alg_mode) == 3'd1) |-> (dout[7] == !$past(prog_d7))) else $error("dq7"); // R4

    AST_TIMEOUT_READY: assert property (@(posedge clk) disable iff (rst)
        ($past(timed_out) && $past(alg_mode) != 3'd0 && $past(alg_mode) != 3'd7) |-> busy_n) else $error("to"); // R5

    AST_ERASE_DQ3: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_start) && ($past(alg_mode) == 3'd3 || $past(alg_mode) == 3'd4))
        |-> (dout[3] && !dout[7])) else $error("dq3"); // R6

    AST_DQ2_HOLD_PROG: assert property (@(posedge clk) disable iff (rst)
        ($past(alg_mode) == 3'd1) |-> $stable(tog2)) else $error("dq2"); // R7

    AST_BUSY_PROG: assert property (@(posedge clk) disable iff (rst)
        ($past(alg_mode) == 3'd1 && !$past(timed_out)) |-> !busy_n) else $error("busy"); // R10

    AST_BUSY_SUSP: assert property (@(posedge clk) disable iff (rst)
        ($past(alg_mode) == 3'd5) |-> busy_n) else $error("susp"); // R10

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        win_run <= PROT_ERASE_CYC) else $error("win"); // R11
endmodule

bind flash_status_gen fsg_checker #(.PROT_ERASE_CYC(PROT_ERASE_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .alg_mode   (alg_mode),
    .timed_out  (timed_out),
    .prog_d7    (prog_d7),
    .rd_start   (rd_start),
    .dout       (dout),
    .busy_n     (busy_n),
    .tog6       (tog6),
    .tog2       (tog2),
    .win_active (win_active)
);

// File: tb/sim_flash_status_gen.sv
`timescale 1ns/1ps
module sim_flash_status_gen;
    localparam int SEC_IDX_W = 4;
    localparam int NUM_SEC   = 1 << SEC_IDX_W;
    localparam int PPC       = 8;
    localparam int PEC       = 40;

    logic clk = 1'b0;
    logic rst;
    logic [2:0] alg_mode;
    logic timed_out, prog_d7, prot_prog_go, prot_erase_go, ce_n, oe_n;
    logic [NUM_SEC-1:0] erase_sel, fail_sel;
    logic [SEC_IDX_W-1:0] rd_sector;
    logic [7:0] array_data, dout;
    logic busy_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    flash_status_gen #(.SEC_IDX_W(SEC_IDX_W), .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC)) u0 (
        .clk(clk), .rst(rst), .alg_mode(alg_mode), .timed_out(timed_out), .prog_d7(prog_d7),
        .erase_sel(erase_sel), .fail_sel(fail_sel), .prot_prog_go(prot_prog_go),
        .prot_erase_go(prot_erase_go), .rd_sector(rd_sector), .ce_n(ce_n), .oe_n(oe_n),
        .array_data(array_data), .dout(dout), .busy_n(busy_n));

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input int sec, input logic [7:0] ad, output logic [7:0] r);
        @(negedge clk);
        rd_sector = SEC_IDX_W'(sec); array_data = ad; ce_n = 0; oe_n = 0;
        @(negedge clk);
        r = dout; ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m, input logic to);
        @(negedge clk);
        alg_mode = m; timed_out = to;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "dout", dout, 8'h00);
        check("R1", "busy_n", busy_n, 1);
    endtask

    task automatic t_idle;
        logic [7:0] r;
        set_mode(3'd0, 0);
        do_read(3, 8'hA5, r); check("R2", "array pass", r, 8'hA5);
        do_read(9, 8'h3C, r); check("R2", "array pass 2", r, 8'h3C);
        @(negedge clk); array_data = 8'hFF;
        repeat (3) @(negedge clk);
        check("R2", "held between accesses", dout, 8'h3C);
        check("R10", "idle busy_n", busy_n, 1);
    endtask

    task automatic t_program;
        logic [7:0] a, b;
        prog_d7 = 1;
        set_mode(3'd1, 0);
        check("R10", "program busy_n", busy_n, 0);
        do_read(0, 8'h11, a);
        do_read(0, 8'h11, b);
        check("R1", "first status dq6", a[6], 0);
        check("R4", "dq7 inverse", a[7], 0);
        check("R3", "dq6 flips", a[6] ^ b[6], 1);
        check("R7", "dq2 held in program", a[2] ^ b[2], 0);
        check("R4", "unused bits", {a[5:3], a[1:0]}, 0);
        prog_d7 = 0;
        do_read(0, 8'h11, a);
        check("R4", "dq7 inverse of 0", a[7], 1);
        set_mode(3'd0, 0);
        check("R10", "idle after program", busy_n, 1);
        do_read(0, 8'h6E, a);
        check("R3", "no status in idle", a, 8'h6E);
    endtask

    task automatic t_timeout;
        logic [7:0] a, b;
        set_mode(3'd1, 1);
        check("R5", "timeout busy_n", busy_n, 1);
        do_read(1, 8'h00, a);
        do_read(1, 8'h00, b);
        check("R5", "dq5 set", a[5], 1);
        check("R5", "dq6 still toggles", a[6] ^ b[6], 1);
        set_mode(3'd0, 0);
    endtask

    task automatic t_window;
        logic [7:0] a, b;
        erase_sel = 16'h0004;
        set_mode(3'd2, 0);
        check("R10", "window busy_n", busy_n, 0);
        do_read(2, 8'h00, a); do_read(2, 8'h00, b);
        check("R6", "dq3 window", a[3], 0);
        check("R4", "dq7 erase", a[7], 0);
        check("R7", "dq2 toggles selected (window)", a[2] ^ b[2], 1);
        do_read(5, 8'h00, a); do_read(5, 8'h00, b);
        check("R7", "dq2 held unselected (window)", a[2] ^ b[2], 0);
    endtask

    task automatic t_serase;
        logic [7:0] a, b;
        set_mode(3'd3, 0);
        do_read(2, 8'h00, a); do_read(2, 8'h00, b);
        check("R6", "dq3 erase", a[3], 1);
        check("R7", "dq2 toggles selected", a[2] ^ b[2], 1);
        check("R3", "dq6 toggles erase", a[6] ^ b[6], 1);
        do_read(7, 8'h00, a); do_read(7, 8'h00, b);
        check("R7", "dq2 held unselected", a[2] ^ b[2], 0);
        check("R3", "dq6 toggles any addr", a[6] ^ b[6], 1);
    endtask

    task automatic t_cerase;
        logic [7:0] a, b;
        erase_sel = '0; fail_sel = 16'h0200;
        set_mode(3'd4, 0);
        do_read(11, 8'h00, a); do_read(11, 8'h00, b);
        check("R8", "chip dq2 any addr", a[2] ^ b[2], 1);
        check("R6", "chip dq3", a[3], 1);
        set_mode(3'd4, 1);
        check("R5", "chip timeout busy_n", busy_n, 1);
        do_read(9, 8'h00, a); do_read(9, 8'h00, b);
        check("R8", "failed sector dq2", a[2] ^ b[2], 1);
        check("R5", "chip dq5", a[5], 1);
        do_read(3, 8'h00, a); do_read(3, 8'h00, b);
        check("R8", "good sector dq2 held", a[2] ^ b[2], 0);
        set_mode(3'd0, 0);
    endtask

    task automatic t_suspend;
        logic [7:0] a, b;
        erase_sel = 16'h0010;
        set_mode(3'd5, 0);
        check("R10", "suspend busy_n", busy_n, 1);
        do_read(4, 8'h00, a); do_read(4, 8'h00, b);
        check("R9", "dq7 suspended hit", a[7], 1);
        check("R9", "dq6 held", a[6] ^ b[6], 0);
        check("R9", "dq2 toggles", a[2] ^ b[2], 1);
        check("R9", "dq5 dq3", {a[5], a[3]}, 0);
        do_read(6, 8'hC3, a);
        check("R9", "non-erasing array", a, 8'hC3);
        prog_d7 = 1;
        set_mode(3'd6, 0);
        check("R10", "suspend-program busy_n", busy_n, 0);
        do_read(6, 8'h00, a); do_read(6, 8'h00, b);
        check("R4", "suspend-program dq7", a[7], 0);
        check("R3", "suspend-program dq6", a[6] ^ b[6], 1);
        check("R7", "suspend-program dq2 unselected", a[2] ^ b[2], 0);
        do_read(4, 8'h00, a); do_read(4, 8'h00, b);
        check("R7", "suspend-program dq2 selected", a[2] ^ b[2], 1);
        set_mode(3'd0, 0);
    endtask

    task automatic pulse(input bit er);
        @(negedge clk);
        if (er) prot_erase_go = 1; else prot_prog_go = 1;
        @(negedge clk);
        prot_erase_go = 0; prot_prog_go = 0;
    endtask

    task automatic t_prot;
        logic [7:0] a;
        int cnt;
        prog_d7 = 0;
        pulse(0);
        do_read(8, 8'h44, a);
        check("R11", "prog window dq7", a[7], 1);
        repeat (PPC + 4) @(negedge clk);
        do_read(8, 8'h44, a);
        check("R11", "array after window", a, 8'h44);
        for (int k = 0; k < 2; k++) begin
            pulse(k == 1);
            cnt = 0;
            for (int i = 0; i < PEC + 10; i++) begin
                @(negedge clk);
                if (!busy_n) cnt++;
            end
            check("R11", k ? "erase window length" : "prog window length", cnt, k ? PEC : PPC);
        end
        pulse(1);
        do_read(8, 8'h44, a);
        check("R11", "erase window dq7/dq3", {a[7], a[3]}, 2'b01);
        repeat (PEC + 4) @(negedge clk);
    endtask

    task automatic t_mode7;
        logic [7:0] a;
        set_mode(3'd7, 0);
        check("R12", "mode 7 busy_n", busy_n, 1);
        do_read(4, 8'h9D, a);
        check("R12", "mode 7 array", a, 8'h9D);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; alg_mode = 0; timed_out = 0; prog_d7 = 0; erase_sel = '0; fail_sel = '0;
        prot_prog_go = 0; prot_erase_go = 0; rd_sector = '0; ce_n = 1; oe_n = 1; array_data = 0;
        repeat (3) @(negedge clk);
        t_reset;
        rst = 0;
        @(negedge clk);
        t_reset;
        t_idle;
        t_program;
        t_timeout;
        t_window;
        t_serase;
        t_cerase;
        t_suspend;
        t_prot;
        t_mode7;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule